// File: doc/BRIEF.md
# Serial Register Slave for a Digital Potentiometer

This block is the two-wire bus front end of a small digitally controlled potentiometer. It samples the bus clock and data lines with the system clock, removes short glitches, and finds START and STOP conditions. When the identity byte names this device it acknowledges. It then takes a register address byte and either one write data byte or, after a repeated START with the read bit set, sends register contents back to the master.

Inside the chip it presents a single-cycle write strobe with address and data, and a single-cycle read request whose answer must be on `reg_rdata` by the end of the following acknowledge clock. The device identity is a fixed five-bit prefix followed by two strap pins, so up to four of these devices can share one bus. While `busy` is high (power-up recall or a non-volatile programming cycle) the block ignores the bus completely.

Top module: `dpot_i2c_slave`

## Requirements
- R1: After reset `sda_oe`, `reg_wr` and `reg_rd` are all low.
- R2: The identity byte is sent MSB first as the prefix 0,1,0,1,0, then `strap[1]`, then `strap[0]`, then the direction bit (1 = read, 0 = write). The block pulls SDA low in the ninth clock only when all seven upper bits match.
- R3: After an identity mismatch the block leaves SDA released and ignores all further clocks until the next START.
- R4: A write (START, identity with bit 0 = 0, address byte, data byte, STOP) gives one single-cycle `reg_wr` pulse carrying that address and data, and all three bytes are acknowledged.
- R5: The write strobe is issued on the SCL fall that ends the data LSB, before the ninth clock rises, together with the start of the ACK.
- R6: A combined read (write-direction identity, address byte, repeated START, read-direction identity) raises `reg_rd` for the stored address and shifts `reg_rdata` out MSB first, each bit changing after an SCL fall.
- R7: When the master acknowledges a read byte another byte is sent from a fresh read request; when it does not, SDA stays released until STOP or START.
- R8: While `busy` is high SDA is released, no strobe is issued and START conditions are ignored, so a frame begun under `busy` is never answered.
- R9: A STOP in the middle of a frame ends it; later clocks without a new START cause no write and no ACK.
- R10: Pulses on SCL or SDA lasting fewer than `FILT_LEN` system clocks have no effect on received data or bus conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap | input | 2 | Identity strap pins, bit 1 then bit 0 in the identity |
| busy | input | 1 | Ignore the bus while high |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read request |
| reg_addr | output | 8 | Register address from the address byte |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid by the end of the ACK clock after `reg_rd` |

## Verification
The bench sweeps every strap setting against every identity value, so a design that compared the strap bits in the wrong order or ignored the prefix would acknowledge foreign devices. It checks that the write strobe appears before the ninth clock rises, which a design committing at STOP or after the ACK would miss, and that bytes clocked after a mismatch, a mid-frame STOP or a frame begun under `busy` produce nothing. Reads are checked with master ACK and NACK, catching a slave that keeps driving after a NACK, and a write with one-cycle spikes on both lines catches a design whose filter counts glitches as clocks or false STARTs.

// File: rtl/dpot_i2c_pkg.sv
package dpot_i2c_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ID,
      ST_ID_ACK,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_TX,
      ST_TX_ACK
   } bus_state_t;
endpackage

// File: rtl/dpot_i2c_line_filter.sv
module dpot_i2c_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end

   generate
      if (FILT_LEN == 1) begin : g_nofilt
         assign clean = sync_q[SYNC_STAGES-1];
      end else begin : g_filt
         logic [FILT_LEN-1:0] hist_q;
         logic                out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '1;
               out_q  <= 1'b1;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
               if (&hist_q)       out_q <= 1'b1;
               else if (~|hist_q) out_q <= 1'b0;
            end
         end
         assign clean = out_q;
      end
   endgenerate
endmodule

// File: rtl/dpot_i2c_cond_detect.sv
module dpot_i2c_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise  = scl & ~scl_q;
   assign scl_fall  = ~scl & scl_q;
   assign start_det = scl & scl_q & sda_q & ~sda;
   assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/dpot_i2c_engine.sv
module dpot_i2c_engine
   import dpot_i2c_pkg::*;
#(
   parameter logic [4:0] ID_PREFIX = 5'b01010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic [1:0]        strap,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_bit,
   output logic              sda_oe,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic [BYTE_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   input  logic [BYTE_W-1:0] reg_rdata
);
   localparam logic [3:0] FULL_BYTE = 4'(BYTE_W);
   localparam logic [3:0] LAST_TX   = 4'(BYTE_W - 1);

   bus_state_t        state;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic              rw_q, mack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; cnt <= '0; rx_sh <= '0; tx_sh <= '0;
         rw_q <= 1'b0; mack_q <= 1'b0; sda_oe <= 1'b0;
         reg_wr <= 1'b0; reg_rd <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      end else begin
         reg_wr <= 1'b0;
         reg_rd <= 1'b0;
         if (busy || stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            state  <= ST_ID;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ID, ST_ADDR, ST_DATA: begin
                  if (scl_rise) begin
                     rx_sh <= {rx_sh[BYTE_W-2:0], sda_bit};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == FULL_BYTE) begin
                     cnt <= '0;
                     if (state == ST_ID) begin
                        if (rx_sh[BYTE_W-1:1] == {ID_PREFIX, strap}) begin
                           rw_q   <= rx_sh[0];
                           reg_rd <= rx_sh[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ID_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_ADDR) begin
                        reg_addr <= rx_sh;
                        sda_oe   <= 1'b1;
                        state    <= ST_ADDR_ACK;
                     end else begin
                        reg_wdata <= rx_sh;
                        reg_wr    <= 1'b1;
                        sda_oe    <= 1'b1;
                        state     <= ST_DATA_ACK;
                     end
                  end
               end
               ST_ID_ACK: if (scl_fall) begin
                  cnt <= '0;
                  if (rw_q) begin
                     tx_sh  <= reg_rdata;
                     sda_oe <= ~reg_rdata[BYTE_W-1];
                     state  <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_ADDR;
                  end
               end
               ST_ADDR_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= ST_DATA;
               end
               ST_DATA_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= ST_IDLE;
               end
               ST_TX: if (scl_fall) begin
                  if (cnt == LAST_TX) begin
                     cnt    <= '0;
                     sda_oe <= 1'b0;
                     state  <= ST_TX_ACK;
                  end else begin
                     tx_sh  <= tx_sh << 1;
                     sda_oe <= ~tx_sh[BYTE_W-2];
                     cnt    <= cnt + 4'd1;
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_bit;
                     reg_rd <= ~sda_bit;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        tx_sh  <= reg_rdata;
                        sda_oe <= ~reg_rdata[BYTE_W-1];
                        state  <= ST_TX;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave #(
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3,
   parameter logic [4:0] ID_PREFIX   = 5'b01010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       sda_oe,
   input  logic [1:0] strap,
   input  logic       busy,
   output logic       reg_wr,
   output logic       reg_rd,
   output logic [7:0] reg_addr,
   output logic [7:0] reg_wdata,
   input  logic [7:0] reg_rdata
);
   localparam int NLINES = 2;

   logic [NLINES-1:0] raw_lines, clean_lines;
   logic scl_rise, scl_fall, start_det, stop_det;

   assign raw_lines = {sda_in, scl_in};

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_line
         dpot_i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw(raw_lines[i]), .clean(clean_lines[i])
         );
      end
   endgenerate

   dpot_i2c_cond_detect u_cond (
      .clk(clk), .rst_n(rst_n), .scl(clean_lines[0]), .sda(clean_lines[1]),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   dpot_i2c_engine #(.ID_PREFIX(ID_PREFIX)) u_eng (
      .clk(clk), .rst_n(rst_n), .busy(busy), .strap(strap),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_bit(clean_lines[1]),
      .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );
endmodule

// File: rtl/dpot_i2c_slave_chk.sv
module dpot_i2c_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       sda_oe,
   input logic       reg_wr,
   input logic       reg_rd,
   input logic [7:0] reg_addr
);
   a_r8_busy_silences: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!sda_oe && !reg_wr && !reg_rd));

   a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> $stable(reg_addr));

   a_r5_commit_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> (sda_oe && !$past(sda_oe)));

   a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);
endmodule

bind dpot_i2c_slave dpot_i2c_slave_chk u_chk (.*);

// File: tb/dpot_i2c_slave_tb.sv
module dpot_i2c_slave_tb;
   localparam int Q = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [1:0] strap = 2'd0;
   logic busy = 1'b0;
   logic sda_oe, reg_wr, reg_rd;
   logic [7:0] reg_addr, reg_wdata;
   logic [7:0] reg_rdata = 8'd0;
   wire sda_line = sda_m & ~sda_oe;

   int checks = 0, errors = 0;
   int wr_cnt = 0, rd_cnt = 0;
   logic [7:0] last_addr = 8'd0, last_data = 8'd0;

   always #2 clk = ~clk;

   dpot_i2c_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
      .strap(strap), .busy(busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   function automatic logic [7:0] rd_val(input logic [7:0] a);
      return 8'(a * 8'd37 + 8'd5);
   endfunction

   always @(posedge clk) begin
      if (reg_wr) begin
         wr_cnt <= wr_cnt + 1;
         last_addr <= reg_addr;
         last_data <= reg_wdata;
      end
      if (reg_rd) begin
         rd_cnt <= rd_cnt + 1;
         reg_rdata <= rd_val(reg_addr);
      end
   end

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
   endtask

   task automatic clk_bit(input logic b, input logic glitch, output logic seen);
      sda_m = b;
      if (glitch) begin
         wq(Q/2); scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q/2);
      end else wq(Q);
      scl_m = 1'b1; wq(Q/2);
      seen = sda_line;
      if (glitch && b) begin
         sda_m = 1'b0; wq(1); sda_m = 1'b1;
      end
      wq(Q/2);
      scl_m = 1'b0;
   endtask

   int wr_before_ack;
   task automatic send_byte(input logic [7:0] v, input logic glitch, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], glitch, s);
      sda_m = 1'b1; wq(Q);
      wr_before_ack = wr_cnt;
      scl_m = 1'b1; wq(Q/2);
      ack = ~sda_line;
      wq(Q/2); scl_m = 1'b0;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] v, output logic any_low);
      logic s;
      any_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, 1'b0, s);
         v[i] = s;
      end
      clk_bit(~mack, 1'b0, s);
      sda_m = 1'b1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic ack, ack2, ack3, dummy;
      logic [7:0] rv;
      int w0, r0;
      wq(5);
      check(sda_oe == 0 && reg_wr == 0 && reg_rd == 0, "R1 reset outputs", {sda_oe, reg_wr, reg_rd}, 0);
      rst_n = 1'b1; wq(10);

      // R2: every strap against every identity strap field, plus a bad prefix
      for (int s = 0; s < 4; s++) begin
         strap = 2'(s);
         for (int k = 0; k < 4; k++) begin
            i2c_start();
            send_byte({5'b01010, 2'(k), 1'b0}, 1'b0, ack);
            check(ack == (k == s), "R2 identity match", ack, (k == s));
            i2c_stop();
         end
         i2c_start();
         send_byte({5'b01011, 2'(s), 1'b0}, 1'b0, ack);
         check(ack == 0, "R2 prefix mismatch", ack, 0);
         i2c_stop();
      end
      strap = 2'd2;

      // R4 / R5: writes with several address and data patterns
      for (int p = 0; p < 4; p++) begin
         logic [7:0] a, d;
         a = 8'(p * 2 + (p == 3 ? 1 : 0));
         d = 8'(8'h77 ^ (p * 8'h5B));
         w0 = wr_cnt;
         i2c_start();
         send_byte({5'b01010, 2'd2, 1'b0}, 1'b0, ack);
         send_byte(a, 1'b0, ack2);
         send_byte(d, 1'b0, ack3);
         check(wr_before_ack == w0 + 1, "R5 commit before ACK clock", wr_before_ack, w0 + 1);
         i2c_stop();
         check(ack && ack2 && ack3, "R4 all bytes acked", {ack, ack2, ack3}, 7);
         check(wr_cnt == w0 + 1, "R4 one strobe", wr_cnt - w0, 1);
         check(last_addr == a && last_data == d, "R4 address and data", {last_addr, last_data}, {a, d});
      end

      // R3: mismatch then bytes with no START
      w0 = wr_cnt;
      i2c_start();
      send_byte({5'b01010, 2'd1, 1'b0}, 1'b0, ack);
      send_byte(8'h00, 1'b0, ack2);
      send_byte(8'h55, 1'b0, ack3);
      i2c_stop();
      check(!ack && !ack2 && !ack3, "R3 silent after mismatch", {ack, ack2, ack3}, 0);
      check(wr_cnt == w0, "R3 no write after mismatch", wr_cnt - w0, 0);

      // R6 / R7: combined read, ACK then NACK
      for (int p = 0; p < 3; p++) begin
         logic [7:0] a;
         a = 8'(p * 5 + 2);
         r0 = rd_cnt;
         i2c_start();
         send_byte({5'b01010, 2'd2, 1'b0}, 1'b0, ack);
         send_byte(a, 1'b0, ack2);
         sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
         send_byte({5'b01010, 2'd2, 1'b1}, 1'b0, ack3);
         check(ack && ack2 && ack3, "R6 read header acked", {ack, ack2, ack3}, 7);
         recv_byte(1'b1, rv, dummy);
         check(rv == rd_val(a), "R6 first read byte", rv, rd_val(a));
         recv_byte(1'b0, rv, dummy);
         check(rv == rd_val(a), "R7 byte after master ACK", rv, rd_val(a));
         check(rd_cnt == r0 + 2, "R7 fresh read request", rd_cnt - r0, 2);
         recv_byte(1'b0, rv, dummy);
         check(rv == 8'hFF, "R7 released after NACK", rv, 8'hFF);
         i2c_stop();
      end

      // R8: busy blocks a whole frame, and a frame started under busy
      w0 = wr_cnt;
      busy = 1'b1;
      i2c_start();
      send_byte({5'b01010, 2'd2, 1'b0}, 1'b0, ack);
      send_byte(8'h00, 1'b0, ack2);
      send_byte(8'h11, 1'b0, ack3);
      i2c_stop();
      check(!ack && !ack2 && !ack3 && wr_cnt == w0, "R8 busy frame ignored", {ack, ack2, ack3}, 0);
      i2c_start();
      busy = 1'b0;
      send_byte({5'b01010, 2'd2, 1'b0}, 1'b0, ack);
      send_byte(8'h00, 1'b0, ack2);
      i2c_stop();
      check(!ack && !ack2 && wr_cnt == w0, "R8 START under busy ignored", {ack, ack2}, 0);

      // R9: STOP after the address byte
      w0 = wr_cnt;
      i2c_start();
      send_byte({5'b01010, 2'd2, 1'b0}, 1'b0, ack);
      send_byte(8'h02, 1'b0, ack2);
      i2c_stop();
      scl_m = 1'b0; wq(Q);
      send_byte(8'h80, 1'b0, ack3);
      scl_m = 1'b1; wq(Q);
      check(ack && ack2 && !ack3 && wr_cnt == w0, "R9 STOP aborts frame", {ack3, 8'(wr_cnt - w0)}, 0);

      // R10: one-cycle spikes on both lines during a write
      w0 = wr_cnt;
      i2c_start();
      send_byte({5'b01010, 2'd2, 1'b0}, 1'b1, ack);
      send_byte(8'h00, 1'b1, ack2);
      send_byte(8'hB6, 1'b1, ack3);
      i2c_stop();
      check(ack && ack2 && ack3 && wr_cnt == w0 + 1 && last_data == 8'hB6,
            "R10 spikes filtered", last_data, 8'hB6);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule